// File: doc/BRIEF.md
# Open-Drain Serial Clock Phase Generator with Wired-AND Synchronization

This block produces the serial clock of an I2C controller acting as bus master. It never drives the line high. It either enables a pull-down or lets the line float, and a bit-clock enable paces the timing. A programmed number of bit ticks sets the low phase and another sets the high phase. A synchronized copy of the real line level is fed back in, and the phase machine follows that level rather than its own intent.

Two rules make the bus clock wired-AND synchronized. First, the high phase does not start counting until the line is actually seen high, so a slow slave or a slower master can stretch the low time. Second, if another device pulls the line low during the high phase, the high phase ends at once and a new low phase is counted in full. The result is a low time set by the slowest device on the bus and a high time set by the fastest. With ordinary tick rates this covers standard (100 kb/s) and fast (400 kb/s) buses.

When the controller runs as a slave, the master timing is parked. After each transferred byte the block holds the line low while the interrupt flag is set, and lets it go once software clears the flag. Two one-cycle strobes pace the data shifter: one in the middle of each high phase for sampling the data line, and one at the start of each low phase for changing it.

Top module: `scl_clock_sync`

## Requirements
- R1: After reset, `scl_oe`, `sample_stb` and `shift_stb` are all 0.
- R2: With `master_act` = 0 and `slave_mode` = 0, `scl_oe` is 0 from the cycle after, and no strobe is produced.
- R3: Once started, the own low phase lasts max(`low_cnt`,1) bit ticks. A `low_cnt` of 0 counts as 1. With a tick on every cycle and no other device, the line stays low for exactly that many cycles.
- R4: After its own low phase the block releases the line and waits for as long as `scl_in` reads 0. High-phase counting starts only from the cycle in which `scl_in` reads 1. A stretched low therefore lasts max(own low, external hold), and the high phase then lasts max(`high_cnt`,1) ticks plus one cycle when the release came from this block.
- R5: If `scl_in` reads 0 during the high phase, the high phase ends at the next clock edge and a full low phase starts. The line low time becomes max(own low, external low).
- R6: The phase counters advance only in cycles with `tick_en` = 1. With `tick_en` = 0 during the low phase, the pull-down stays on.
- R7: `sample_stb` pulses once per uninterrupted high phase, in the tick where the high count (0-based) equals floor(max(`high_cnt`,1)/2), and only while `scl_in` is 1.
- R8: `shift_stb` is a single-cycle pulse in the first cycle of every own low phase.
- R9: With `slave_mode` = 1 and `irq_flag` = 1, a 0 on `scl_in` makes `scl_oe` 1 from the next cycle. It stays 1 while `irq_flag` stays 1, and drops in the cycle after `irq_flag` goes to 0.
- R10: With `slave_mode` = 1 and `irq_flag` = 1 while `scl_in` stays 1, `scl_oe` stays 0.
- R11: With `slave_mode` = 1, the master timing is parked and `master_act` is ignored: no strobes, and no pull-down unless R9 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Bit-clock enable; one phase count per asserted cycle |
| master_act | input | 1 | Controller is mastering a transfer; 0 means idle |
| scl_in | input | 1 | Synchronized level of the shared clock line |
| low_cnt | input | CNT_W | Low-phase length in ticks (0 treated as 1) |
| high_cnt | input | CNT_W | High-phase length in ticks (0 treated as 1) |
| slave_mode | input | 1 | Controller operates as a slave |
| irq_flag | input | 1 | Interrupt flag; holds the line low in slave mode |
| scl_oe | output | 1 | Pull-down enable for the open-drain clock line |
| sample_stb | output | 1 | Mid-high strobe for sampling the data line |
| shift_stb | output | 1 | Start-of-low strobe for updating the data line |

## Verification
The assertions check the phase-by-phase reactions on every cycle. A release is always followed by a wait on a low line, an external low always ends a high phase, a tick-less cycle never ends a low phase, the strobes stay in their phases and never overlap, and the slave hold follows the flag. Only the bench scenarios can show the resulting bus waveform. It checks the low length as the maximum of the own and external low times, the high length as the shorter of the two, where the mid-high strobe lands, and that a zero length means one tick. To do this the bench runs a wired-AND line model against stretching slaves and faster masters.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOW    = 2'd1,
    PH_WAITHI = 2'd2,
    PH_HIGH   = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/scl_master_fsm.sv
module scl_master_fsm
  import scl_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic       scl_in,
  input  logic       low_last,
  input  logic       high_last,
  output scl_phase_e phase,
  output logic       cnt_clr,
  output logic       cnt_inc
);
  scl_phase_e nxt;

  always_comb begin
    nxt     = phase;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (run) begin
          nxt     = PH_LOW;
          cnt_clr = 1'b1;
        end
      end
      PH_LOW: begin
        if (!run) begin
          nxt     = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (tick_en) begin
          if (low_last) begin
            nxt     = PH_WAITHI;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      PH_WAITHI: begin
        if (!run) begin
          nxt     = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (scl_in) begin
          nxt     = PH_HIGH;
          cnt_clr = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!run) begin
          nxt     = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (!scl_in) begin
          nxt     = PH_LOW;
          cnt_clr = 1'b1;
        end else if (tick_en) begin
          if (high_last) begin
            nxt     = PH_LOW;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      default: begin
        nxt     = PH_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/scl_slave_hold.sv
module scl_slave_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic irq_flag,
  input  logic scl_in,
  output logic hold_low
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold_low <= 1'b0;
    else if (!slave_mode || !irq_flag) hold_low <= 1'b0;
    else if (!scl_in)                 hold_low <= 1'b1;
  end
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scl_phase_e       phase,
  input  logic             tick_en,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] mid_point,
  output logic             sample_stb,
  output logic             shift_stb
);
  logic was_low_q;
  logic in_low;

  assign in_low = (phase == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_low_q <= 1'b0;
    else        was_low_q <= in_low;
  end

  assign shift_stb  = in_low && !was_low_q;
  assign sample_stb = (phase == PH_HIGH) && tick_en && scl_in && (cnt == mid_point);
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             master_act,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             slave_mode,
  input  logic             irq_flag,
  output logic             scl_oe,
  output logic             sample_stb,
  output logic             shift_stb
);
  // Phase length with zero mapped to one tick.
  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  // 0-based tick index of the mid-high sampling point.
  function automatic logic [CNT_W-1:0] mid_tick(input logic [CNT_W-1:0] v);
    return eff_len(v) >> 1;
  endfunction

  logic             run_master;
  logic [CNT_W-1:0] cnt_w;
  logic             cnt_clr_w;
  logic             cnt_inc_w;
  logic             low_last_w;
  logic             high_last_w;
  logic             master_low_w;
  logic             hold_low_w;
  scl_phase_e       phase_w;

  assign run_master  = master_act && !slave_mode;
  assign low_last_w  = (cnt_w == eff_len(low_cnt)  - CNT_W'(1));
  assign high_last_w = (cnt_w == eff_len(high_cnt) - CNT_W'(1));

  scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr_w),
    .inc  (cnt_inc_w),
    .cnt  (cnt_w)
  );

  scl_master_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_master),
    .tick_en  (tick_en),
    .scl_in   (scl_in),
    .low_last (low_last_w),
    .high_last(high_last_w),
    .phase    (phase_w),
    .cnt_clr  (cnt_clr_w),
    .cnt_inc  (cnt_inc_w)
  );

  scl_slave_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_mode(slave_mode),
    .irq_flag  (irq_flag),
    .scl_in    (scl_in),
    .hold_low  (hold_low_w)
  );

  scl_strobe_gen #(.CNT_W(CNT_W)) u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_w),
    .tick_en   (tick_en),
    .scl_in    (scl_in),
    .cnt       (cnt_w),
    .mid_point (mid_tick(high_cnt)),
    .sample_stb(sample_stb),
    .shift_stb (shift_stb)
  );

  assign master_low_w = (phase_w == PH_LOW);
  assign scl_oe       = master_low_w || hold_low_w;
endmodule

// File: rtl/scl_clock_sync_chk.sv
module scl_clock_sync_chk
  import scl_sync_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       master_act,
  input logic       slave_mode,
  input logic       irq_flag,
  input logic       scl_in,
  input logic       scl_oe,
  input logic       sample_stb,
  input logic       shift_stb,
  input scl_phase_e phase
);
  logic running;
  assign running = master_act && !slave_mode;

  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_act && !slave_mode) |=> !scl_oe);

  p_wait_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAITHI && !scl_in && running) |=> (phase == PH_WAITHI));

  p_pull_ends_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && !scl_in && running) |=> (phase == PH_LOW && scl_oe));

  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW && !tick_en && running) |=> (phase == PH_LOW));

  p_sample_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (phase == PH_HIGH && scl_in && !scl_oe));

  p_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, shift_stb}));

  p_shift_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> !shift_stb);

  p_shift_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> scl_oe);

  p_slave_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && irq_flag && !scl_in) |=> scl_oe);

  p_slave_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && !irq_flag) |=> !scl_oe);

  p_slave_parks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> (phase == PH_IDLE && !sample_stb && !shift_stb));
endmodule

bind scl_clock_sync scl_clock_sync_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .master_act(master_act),
  .slave_mode(slave_mode),
  .irq_flag  (irq_flag),
  .scl_in    (scl_in),
  .scl_oe    (scl_oe),
  .sample_stb(sample_stb),
  .shift_stb (shift_stb),
  .phase     (phase_w)
);

// File: tb/scl_clock_sync_tb.sv
module scl_clock_sync_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b1;
  logic             master_act = 1'b0;
  logic [CNT_W-1:0] low_cnt = '0;
  logic [CNT_W-1:0] high_cnt = '0;
  logic             slave_mode = 1'b0;
  logic             irq_flag = 1'b0;
  logic             scl_oe, sample_stb, shift_stb;
  logic             ext_low = 1'b0;
  logic             ext_force = 1'b0;
  logic             scl_in;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // wired-AND line
  assign scl_in = !scl_oe && !ext_low && !ext_force;

  always #(CLK_PERIOD/2) clk = !clk;

  scl_clock_sync #(.CNT_W(CNT_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .master_act(master_act),
    .scl_in    (scl_in),
    .low_cnt   (low_cnt),
    .high_cnt  (high_cnt),
    .slave_mode(slave_mode),
    .irq_flag  (irq_flag),
    .scl_oe    (scl_oe),
    .sample_stb(sample_stb),
    .shift_stb (shift_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // scenario parameters: mode 0 plain, 1 stretching slave, 2 faster master
  int m_mode = 0, m_l = 1, m_h = 1, m_t = 2, m_k = 2, m_e = 1;
  bit ext_en = 1'b0;
  bit chk_en = 1'b0;

  function automatic int exp_low();
    if (m_mode == 1) return imax(eff(m_l), m_t);
    if (m_mode == 2) return imax(eff(m_l), m_e);
    return eff(m_l);
  endfunction

  // 0 when the line was released by the other device at a falling clock edge
  function automatic int rel_off();
    if (m_mode == 1 && m_t > eff(m_l)) return 0;
    if (m_mode == 2 && m_e > eff(m_l)) return 0;
    return 1;
  endfunction

  function automatic int exp_high();
    if (m_mode == 2) return m_k;
    return eff(m_h) + rel_off();
  endfunction

  function automatic int exp_spos();
    return eff(m_h) / 2 + rel_off();
  endfunction

  function automatic int exp_scnt();
    if (m_mode == 2) return (m_k > exp_spos()) ? 1 : 0;
    return 1;
  endfunction

  // line monitor and external device model, both at the falling edge
  bit prev_line = 1'b1;
  bit prev_oe = 1'b0;
  int run_len = 0;
  int s_cnt = 0, s_pos = -1, h_cnt = 0, h_pos = -1;
  int ext_cnt = 0;

  always @(negedge clk) begin
    if (scl_in == prev_line) run_len++;
    else begin
      if (chk_en && !prev_line) begin
        chk(run_len == exp_low(), "R3/R4/R5 low length", run_len, exp_low());
        chk(h_cnt == 1 && h_pos == 0, "R8 shift strobe", h_pos, 0);
      end
      if (chk_en && prev_line) begin
        chk(run_len == exp_high(), "R4/R5 high length", run_len, exp_high());
        chk(s_cnt == exp_scnt(), "R7 sample strobe count", s_cnt, exp_scnt());
        if (exp_scnt() == 1)
          chk(s_pos == exp_spos(), "R7 sample strobe position", s_pos, exp_spos());
      end
      run_len = 1;
      s_cnt = 0; s_pos = -1; h_cnt = 0; h_pos = -1;
    end
    if (sample_stb) begin s_cnt++; s_pos = run_len - 1; end
    if (shift_stb)  begin h_cnt++; h_pos = run_len - 1; end
    prev_line = scl_in;
    if (ext_en && m_mode == 1 && scl_oe && !prev_oe) ext_cnt = m_t - 1;
    else if (ext_en && m_mode == 2 && scl_in && run_len == m_k) ext_cnt = m_e;
    else if (ext_cnt > 0) ext_cnt--;
    ext_low = (ext_cnt > 0);
    prev_oe = scl_oe;
  end

  task automatic trial(input int mode, input int l, input int h, input int t,
                       input int k, input int e);
    int rises = 0;
    bit po = 1'b0;
    @(posedge clk);
    m_mode = mode; m_l = l; m_h = h; m_t = t; m_k = k; m_e = e;
    ext_en = (mode == 1);
    @(negedge clk);
    low_cnt = CNT_W'(l); high_cnt = CNT_W'(h);
    master_act = 1'b1;
    while (rises < 2) begin
      @(negedge clk);
      if (scl_oe && !po) begin
        rises++;
        @(posedge clk);
        if (rises == 1) ext_en = 1'b1;
        else chk_en = 1'b1;
      end
      po = scl_oe;
    end
    repeat (5 * (exp_low() + exp_high() + 4)) @(posedge clk);
    chk_en = 1'b0;
    ext_en = 1'b0;
    @(negedge clk);
    master_act = 1'b0;
    repeat (45) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!scl_oe && !sample_stb && !shift_stb, "R1 reset outputs", {scl_oe, sample_stb, shift_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe, "R1 after reset release", scl_oe, 0);

    // R2: idle keeps line released, no strobes
    begin
      int bad = 0;
      repeat (30) begin
        @(negedge clk);
        if (scl_oe || sample_stb || shift_stb) bad++;
      end
      chk(bad == 0, "R2 idle released", bad, 0);
    end

    // R3 boundary: zero lengths count as one tick
    trial(0, 0, 0, 2, 2, 1);
    // directed corners
    trial(0, 7, 4, 2, 2, 1);
    trial(1, 3, 6, 12, 2, 1);   // R4 stretched low
    trial(1, 9, 5, 4, 2, 1);    // R4 shorter external hold
    trial(2, 5, 9, 2, 3, 14);   // R5 faster master, longer low
    trial(2, 8, 9, 2, 6, 2);    // R5 faster master, shorter low

    // constrained random scenarios
    for (int i = 0; i < 24; i++) begin
      int md = $urandom_range(2, 0);
      int l  = $urandom_range(20, 1);
      int h  = $urandom_range(20, 2);
      int t  = $urandom_range(l + 12, 2);
      int k  = $urandom_range(h, 2);
      int e  = $urandom_range(30, 1);
      trial(md, l, h, t, k, e);
    end

    // R6: no tick, low phase frozen
    @(negedge clk);
    low_cnt = 10'd4; high_cnt = 10'd4;
    master_act = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    begin
      int bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (!scl_oe) bad++;
      end
      chk(bad == 0, "R6 low held without tick", bad, 0);
    end
    tick_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(!scl_oe, "R6 low ends once ticks resume", scl_oe, 0);
    master_act = 1'b0;
    repeat (5) @(negedge clk);
    chk(!scl_oe, "R2 idle after stop", scl_oe, 0);

    // R10: slave mode, flag set, line high
    slave_mode = 1'b1; irq_flag = 1'b1;
    repeat (8) @(negedge clk);
    chk(!scl_oe, "R10 no hold while line high", scl_oe, 0);
    // R9: line pulled low by the master on the bus
    ext_force = 1'b1;
    repeat (3) @(negedge clk);
    ext_force = 1'b0;
    begin
      int bad = 0;
      repeat (12) begin
        @(negedge clk);
        if (!scl_oe || scl_in) bad++;
      end
      chk(bad == 0, "R9 hold until flag clears", bad, 0);
    end
    irq_flag = 1'b0;
    @(negedge clk);
    chk(!scl_oe, "R9 release after flag clear", scl_oe, 0);
    chk(scl_in, "R9 line free after release", scl_in, 1);

    // R11: master request ignored in slave mode
    master_act = 1'b1;
    begin
      int bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (scl_oe || sample_stb || shift_stb) bad++;
      end
      chk(bad == 0, "R11 master parked in slave mode", bad, 0);
    end
    master_act = 1'b0;
    slave_mode = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule